// File: doc/BRIEF.md
# UART Register Bank with Divisor-Latch Banking

This block is the memory-mapped register front end of a 16550-style serial port. A synchronous bus port with an access-size input reaches byte-wide registers on a four-byte stride. The registers cover transmit and receive data, interrupt enables, an interrupt identification value, line control, modem control, line status, modem status, a scratch byte and a global control byte. Setting the latch-select bit in line control replaces the data and interrupt-enable slots with the two halves of the baud divisor. Reads return data in the same cycle as the request. A rejected access raises the error output for that cycle and has no side effects.

On the serializer side the bank pushes each transmitted byte out as a one-cycle strobe. It pops the receiver when a data read consumes an external byte, and it takes the transmitter-idle, line-error and modem-status inputs. With loopback enabled, a transmitted byte is also kept in a one-entry holder, and the next data read returns it in place of external data. Two interrupt strobes are produced. One follows data writes when the transmit interrupt is enabled. The other comes from a periodic poll of receive readiness.

Top module: `uart_regbank`

## Requirements
- R1: Slot index is address bits [7:2]: 0 data, 1 interrupt enable, 2 interrupt identification, 3 line control, 4 modem control, 5 line status, 6 modem status, 7 scratch, 9 global control. While line-control bit 7 is 1, slot 0 accesses the divisor low byte and slot 1 the divisor high byte.
- R2: After reset, divisor low reads 0x01, interrupt identification reads 0x01, the stored line-status bits are 0x60, and every other register reads 0x00.
- R3: Any bus_size other than 1 (16-bit) gives bus_err for that request, whatever the address, and the access has no effect.
- R4: Slot 8, slot indexes above 9, and addresses with bits [1:0] nonzero give bus_err with no effect on any register or strobe.
- R5: Writes to interrupt identification, line status and modem status change nothing. Line control, modem control, scratch and global control read back what was written.
- R6: A line-status read returns the stored bits ORed with live status: bit 0 data ready, bits 5 and 6 both equal to tx_idle. line_err[3:0] accumulates into bits 4:1. The read clears the stored bits, but errors present in the same cycle stay stored.
- R7: With modem-control bit 4 (loopback) set, a data write fills the one-entry holder. The next data read returns that byte and empties the holder. Later reads repeat the last received byte.
- R8: While loopback is set, external receive data is neither returned nor popped.
- R9: A data write while interrupt-enable bit 1 is set gives a one-cycle tx_irq pulse in the following cycle. tx_push with tx_byte occurs on every data write.
- R10: While interrupt-enable bit 0 is set, every POLL_CYCLES cycles rx_irq pulses for one cycle if data ready was true. Clearing the bit stops and restarts the poll count.
- R11: Data ready is true when the holder is full, or when loopback is off and rx_avail is high. A non-loopback data read with rx_avail high returns rx_byte and pulses rx_pop.
- R12: Only wdata[7:0] is stored. bus_rdata[15:8] is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address within the bank |
| bus_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, same cycle |
| bus_err | output | 1 | Access rejected |
| tx_push | output | 1 | Byte strobe toward transmitter |
| tx_byte | output | 8 | Transmitted byte |
| tx_idle | input | 1 | Transmitter holding and shift empty |
| rx_avail | input | 1 | External receiver has a byte |
| rx_byte | input | 8 | External received byte |
| rx_pop | output | 1 | Consume external byte |
| line_err | input | 4 | Overrun, parity, framing, break events |
| modem_st | input | 8 | Live modem status |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive poll interrupt pulse |

## Verification
Two events can fall in the same cycle: the poll expiring and a data read that consumes the only ready byte. Reads are issued after idle gaps of every length across a short poll period, so each phase of the poll counter gets hit. The model requires the pulse to reflect readiness before the read. A line-status read that coincides with a new line_err pulse is a second such pair, and the next read must still show that error.

// File: rtl/uart_rb_pkg.sv
package uart_rb_pkg;

    localparam int REG_W       = 8;
    localparam int BUS_W       = 16;
    localparam int SLOT_IDX_W  = 6;

    localparam int LCR_LATCH   = 7;
    localparam int MCR_LOOP    = 4;
    localparam int IER_RX      = 0;
    localparam int IER_TX      = 1;
    localparam int LSR_DR      = 0;
    localparam int LSR_THRE    = 5;
    localparam int LSR_TEMT    = 6;

    localparam logic [REG_W-1:0] RST_DIV_LO = 8'h01;
    localparam logic [REG_W-1:0] RST_IID    = 8'h01;
    localparam logic [REG_W-1:0] RST_LSTAT  = 8'h60;

    localparam logic [1:0] SIZE_HALF = 2'd1;

    typedef enum logic [3:0] {
        SL_DATA  = 4'd0,
        SL_IEN   = 4'd1,
        SL_IID   = 4'd2,
        SL_LCTL  = 4'd3,
        SL_MCTL  = 4'd4,
        SL_LSTAT = 4'd5,
        SL_MSTAT = 4'd6,
        SL_SCR   = 4'd7,
        SL_GCTL  = 4'd9,
        SL_DIVLO = 4'd10,
        SL_DIVHI = 4'd11,
        SL_NONE  = 4'd15
    } slot_e;

    typedef struct packed {
        logic  err;
        slot_e slot;
    } dec_t;

    function automatic logic [REG_W-1:0] live_status(input logic dr, input logic idle);
        logic [REG_W-1:0] v;
        v = '0;
        v[LSR_DR]   = dr;
        v[LSR_THRE] = idle;
        v[LSR_TEMT] = idle;
        return v;
    endfunction

    function automatic logic [REG_W-1:0] err_bits(input logic [3:0] e);
        return {3'b000, e, 1'b0};
    endfunction

endpackage

// File: rtl/uart_rb_decode.sv
module uart_rb_decode
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    input  logic              latch,
    output dec_t              dec
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    assign idx = addr[ADDR_W-1:2];

    always_comb begin
        dec.err  = 1'b0;
        dec.slot = SL_NONE;
        if (size != SIZE_HALF) begin
            dec.err = 1'b1;
        end else if (addr[1:0] != 2'b00) begin
            dec.err = 1'b1;
        end else begin
            case (idx)
                IDX_W'(0): dec.slot = latch ? SL_DIVLO : SL_DATA;
                IDX_W'(1): dec.slot = latch ? SL_DIVHI : SL_IEN;
                IDX_W'(2): dec.slot = SL_IID;
                IDX_W'(3): dec.slot = SL_LCTL;
                IDX_W'(4): dec.slot = SL_MCTL;
                IDX_W'(5): dec.slot = SL_LSTAT;
                IDX_W'(6): dec.slot = SL_MSTAT;
                IDX_W'(7): dec.slot = SL_SCR;
                IDX_W'(9): dec.slot = SL_GCTL;
                default:   dec.err  = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/uart_rb_holder.sv
module uart_rb_holder
    import uart_rb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REG_W-1:0] load_byte,
    input  logic             take,
    output logic             full,
    output logic [REG_W-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            held <= '0;
        end else if (load) begin
            full <= 1'b1;
            held <= load_byte;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_rb_poll.sv
module uart_rb_poll #(
    parameter int POLL_CYCLES = 10000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic ready,
    output logic pulse
);
    localparam int CNT_W = (POLL_CYCLES > 1) ? $clog2(POLL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (cnt == LAST) begin
            cnt   <= '0;
            pulse <= ready;
        end else begin
            cnt   <= cnt + CNT_W'(1);
            pulse <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
    import uart_rb_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int POLL_CYCLES = 10000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              bus_err,
    output logic              tx_push,
    output logic [7:0]        tx_byte,
    input  logic              tx_idle,
    input  logic              rx_avail,
    input  logic [7:0]        rx_byte,
    output logic              rx_pop,
    input  logic [3:0]        line_err,
    input  logic [7:0]        modem_st,
    output logic              tx_irq,
    output logic              rx_irq
);
    logic [REG_W-1:0] div_lo_q, div_hi_q, ien_q, lctl_q, mctl_q, scr_q, gctl_q;
    logic [REG_W-1:0] lstat_q, rbr_q;
    logic             hold_full;
    logic [REG_W-1:0] hold_byte;
    dec_t             dec;

    uart_rb_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr  (bus_addr),
        .size  (bus_size),
        .latch (lctl_q[LCR_LATCH]),
        .dec   (dec)
    );

    logic acc, wr, rd, data_wr, data_rd, lstat_rd, loop_on, ext_ok, ready;
    assign acc      = bus_req && !dec.err;
    assign wr       = acc && bus_we;
    assign rd       = acc && !bus_we;
    assign data_wr  = wr && (dec.slot == SL_DATA);
    assign data_rd  = rd && (dec.slot == SL_DATA);
    assign lstat_rd = rd && (dec.slot == SL_LSTAT);
    assign loop_on  = mctl_q[MCR_LOOP];
    assign ext_ok   = !loop_on && rx_avail;
    assign ready    = hold_full || ext_ok;

    assign bus_err  = bus_req && dec.err;
    assign tx_push  = data_wr;
    assign tx_byte  = bus_wdata[7:0];
    assign rx_pop   = data_rd && !hold_full && ext_ok;

    uart_rb_holder u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (data_wr && loop_on),
        .load_byte (bus_wdata[7:0]),
        .take      (data_rd),
        .full      (hold_full),
        .held      (hold_byte)
    );

    uart_rb_poll #(.POLL_CYCLES(POLL_CYCLES)) u_poll (
        .clk    (clk),
        .rst    (rst),
        .enable (ien_q[IER_RX]),
        .ready  (ready),
        .pulse  (rx_irq)
    );

    logic [REG_W-1:0] rx_value;
    always_comb begin
        if (hold_full)   rx_value = hold_byte;
        else if (ext_ok) rx_value = rx_byte;
        else             rx_value = rbr_q;
    end

    logic [REG_W-1:0] rd8;
    always_comb begin
        rd8 = '0;
        if (rd) begin
            case (dec.slot)
                SL_DATA:  rd8 = rx_value;
                SL_IEN:   rd8 = ien_q;
                SL_DIVLO: rd8 = div_lo_q;
                SL_DIVHI: rd8 = div_hi_q;
                SL_IID:   rd8 = RST_IID;
                SL_LCTL:  rd8 = lctl_q;
                SL_MCTL:  rd8 = mctl_q;
                SL_LSTAT: rd8 = lstat_q | live_status(ready, tx_idle);
                SL_MSTAT: rd8 = modem_st;
                SL_SCR:   rd8 = scr_q;
                SL_GCTL:  rd8 = gctl_q;
                default:  rd8 = '0;
            endcase
        end
    end
    assign bus_rdata = {{(BUS_W-REG_W){1'b0}}, rd8};

    always_ff @(posedge clk) begin
        if (rst) begin
            div_lo_q <= RST_DIV_LO;
            div_hi_q <= '0;
            ien_q    <= '0;
            lctl_q   <= '0;
            mctl_q   <= '0;
            scr_q    <= '0;
            gctl_q   <= '0;
        end else if (wr) begin
            case (dec.slot)
                SL_DIVLO: div_lo_q <= bus_wdata[7:0];
                SL_DIVHI: div_hi_q <= bus_wdata[7:0];
                SL_IEN:   ien_q    <= bus_wdata[7:0];
                SL_LCTL:  lctl_q   <= bus_wdata[7:0];
                SL_MCTL:  mctl_q   <= bus_wdata[7:0];
                SL_SCR:   scr_q    <= bus_wdata[7:0];
                SL_GCTL:  gctl_q   <= bus_wdata[7:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lstat_q <= RST_LSTAT;
        end else if (lstat_rd) begin
            lstat_q <= err_bits(line_err);
        end else begin
            lstat_q <= lstat_q | err_bits(line_err);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbr_q  <= '0;
            tx_irq <= 1'b0;
        end else begin
            if (data_rd) rbr_q <= rx_value;
            tx_irq <= data_wr && ien_q[IER_TX];
        end
    end
endmodule

// File: rtl/uart_rb_chk.sv
module uart_rb_chk #(
    parameter int POLL_CYCLES = 10000
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_req,
    input logic [1:0]  bus_size,
    input logic        bus_err,
    input logic [15:0] bus_rdata,
    input logic        tx_push,
    input logic        rx_pop,
    input logic        tx_irq,
    input logic        rx_irq,
    input logic [7:0]  mctl_q
);
    AST_SIZE_REJECT: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_size != 2'd1) |-> bus_err); // R3
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> (!tx_push && !rx_pop)); // R4
    AST_TX_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        tx_irq |-> $past(tx_push)); // R9
    AST_RX_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rx_irq |=> !rx_irq); // R10
    AST_LOOP_NO_POP: assert property (@(posedge clk) disable iff (rst)
        rx_pop |-> !mctl_q[4]); // R8
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[15:8] == 8'h00); // R12
endmodule

bind uart_regbank uart_rb_chk #(.POLL_CYCLES(POLL_CYCLES)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_req   (bus_req),
    .bus_size  (bus_size),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .tx_push   (tx_push),
    .rx_pop    (rx_pop),
    .tx_irq    (tx_irq),
    .rx_irq    (rx_irq),
    .mctl_q    (mctl_q)
);

// File: tb/test_uart_regbank.sv
`timescale 1ns/100ps
module test_uart_regbank;
    localparam int P = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_req = 0, bus_we = 0;
    logic [7:0] bus_addr = 0;
    logic [1:0] bus_size = 1;
    logic [15:0] bus_wdata = 0;
    logic [15:0] bus_rdata;
    logic bus_err, tx_push, rx_pop, tx_irq, rx_irq;
    logic [7:0] tx_byte;
    logic tx_idle = 1, rx_avail = 0;
    logic [7:0] rx_byte = 0;
    logic [3:0] line_err = 0;
    logic [7:0] modem_st = 8'h00;

    always #2.5 clk = ~clk;

    uart_regbank #(.ADDR_W(8), .POLL_CYCLES(P)) i_uart_regbank (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .tx_push(tx_push),
        .tx_byte(tx_byte), .tx_idle(tx_idle), .rx_avail(rx_avail),
        .rx_byte(rx_byte), .rx_pop(rx_pop), .line_err(line_err),
        .modem_st(modem_st), .tx_irq(tx_irq), .rx_irq(rx_irq)
    );

    int total = 0, bad = 0;
    bit done = 0;

    // reference state
    logic [7:0] m_dll, m_dlh, m_ier, m_lcr, m_mcr, m_scr, m_gctl, m_stick, m_rbr, m_hb;
    bit m_hv, m_txirq, m_rxirq;
    int m_cnt;

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_dll = 8'h01; m_dlh = 0; m_ier = 0; m_lcr = 0; m_mcr = 0; m_scr = 0; m_gctl = 0;
        m_stick = 8'h60; m_rbr = 0; m_hb = 0; m_hv = 0; m_txirq = 0; m_rxirq = 0; m_cnt = 0;
    endtask

    // one bus cycle, compared against the model, then the model steps
    task automatic cyc(input bit req, input bit we, input logic [7:0] addr,
                       input logic [1:0] size, input logic [15:0] wd, input string tag);
        bit err_e, ok, dlab, loop, dr, pop_e, push_e, nt, nr;
        int slot;
        logic [7:0] rv;
        bus_req = req; bus_we = we; bus_addr = addr; bus_size = size; bus_wdata = wd;
        #0.5;
        slot = int'(addr[7:2]);
        err_e = req && (size != 2'd1 || addr[1:0] != 0 || slot == 8 || slot > 9);
        ok = req && !err_e;
        dlab = m_lcr[7]; loop = m_mcr[4];
        dr = m_hv || (!loop && rx_avail);
        rv = 0; pop_e = 0;
        if (ok && !we) begin
            case (slot)
                0: if (dlab) rv = m_dll;
                   else begin
                       rv = m_hv ? m_hb : ((!loop && rx_avail) ? rx_byte : m_rbr);
                       pop_e = !m_hv && !loop && rx_avail;
                   end
                1: rv = dlab ? m_dlh : m_ier;
                2: rv = 8'h01;
                3: rv = m_lcr;
                4: rv = m_mcr;
                5: rv = m_stick | {1'b0, tx_idle, tx_idle, 4'b0, dr};
                6: rv = modem_st;
                7: rv = m_scr;
                9: rv = m_gctl;
                default: rv = 0;
            endcase
        end
        push_e = ok && we && slot == 0 && !dlab;
        chk(tag, "bus_err", 16'(bus_err), 16'(err_e));
        if (ok && !we) chk(tag, "rdata", bus_rdata, {8'h00, rv});
        chk(tag, "tx_push", 16'(tx_push), 16'(push_e));
        if (push_e) chk(tag, "tx_byte", 16'(tx_byte), 16'(wd[7:0]));
        chk(tag, "rx_pop", 16'(rx_pop), 16'(pop_e));
        chk("R9", "tx_irq", 16'(tx_irq), 16'(m_txirq));
        chk("R10", "rx_irq", 16'(rx_irq), 16'(m_rxirq));
        @(posedge clk);
        nt = push_e && m_ier[1];
        nr = 0;
        if (!m_ier[0]) m_cnt = 0;
        else if (m_cnt == P - 1) begin m_cnt = 0; nr = dr; end
        else m_cnt++;
        if (ok && !we && slot == 5) m_stick = {3'b0, line_err, 1'b0};
        else m_stick = m_stick | {3'b0, line_err, 1'b0};
        if (ok && !we && slot == 0 && !dlab) begin
            if (m_hv) begin m_rbr = m_hb; m_hv = 0; end
            else if (!loop && rx_avail) m_rbr = rx_byte;
        end
        if (ok && we) begin
            case (slot)
                0: if (dlab) m_dll = wd[7:0];
                   else if (loop) begin m_hv = 1; m_hb = wd[7:0]; end
                1: if (dlab) m_dlh = wd[7:0]; else m_ier = wd[7:0];
                3: m_lcr = wd[7:0];
                4: m_mcr = wd[7:0];
                7: m_scr = wd[7:0];
                9: m_gctl = wd[7:0];
                default: ;
            endcase
        end
        m_txirq = nt; m_rxirq = nr;
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input string tag);
        cyc(1, 1, a, 2'd1, d, tag);
    endtask
    task automatic rd(input logic [7:0] a, input string tag);
        cyc(1, 0, a, 2'd1, 16'h0, tag);
    endtask
    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h0, 2'd1, 16'h0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R2: reset values
        rd(8'h00, "R2"); rd(8'h04, "R2"); rd(8'h08, "R2"); rd(8'h0C, "R2");
        rd(8'h10, "R2"); rd(8'h14, "R2"); rd(8'h14, "R2"); rd(8'h1C, "R2");
        rd(8'h24, "R2");
        wr(8'h0C, 16'h0080, "R1"); rd(8'h00, "R2");
        // R1: banking
        wr(8'h00, 16'h0034, "R1"); wr(8'h04, 16'h0012, "R1");
        rd(8'h00, "R1"); rd(8'h04, "R1");
        wr(8'h0C, 16'h0000, "R1"); rd(8'h04, "R1");
        wr(8'h04, 16'h0000, "R1");
        wr(8'h0C, 16'h0080, "R1"); rd(8'h00, "R1"); wr(8'h0C, 16'h0003, "R1");
        // R12: upper byte discarded
        wr(8'h1C, 16'hAB12, "R12"); rd(8'h1C, "R12");
        wr(8'h24, 16'hFF5C, "R12"); rd(8'h24, "R12");
        // R3: size errors (also on unmapped addresses)
        cyc(1, 1, 8'h1C, 2'd0, 16'h0099, "R3"); cyc(1, 1, 8'h1C, 2'd2, 16'h0099, "R3");
        cyc(1, 0, 8'h40, 2'd3, 16'h0, "R3"); cyc(1, 1, 8'h00, 2'd0, 16'h0055, "R3");
        rd(8'h1C, "R3");
        // R4: unmapped
        wr(8'h20, 16'h0011, "R4"); rd(8'h20, "R4"); wr(8'h40, 16'h0011, "R4");
        wr(8'h1E, 16'h0066, "R4"); wr(8'h02, 16'h0066, "R4"); rd(8'h1C, "R4");
        // R5: ignored writes and storage
        wr(8'h08, 16'h00FF, "R5"); wr(8'h14, 16'h00FF, "R5"); wr(8'h18, 16'h00FF, "R5");
        rd(8'h08, "R5"); rd(8'h14, "R5");
        modem_st = 8'hB3; rd(8'h18, "R5");
        wr(8'h10, 16'h0003, "R5"); rd(8'h10, "R5"); rd(8'h0C, "R5");
        // R6: sticky line status
        line_err = 4'b0101; idle(1, "R6"); line_err = 0;
        tx_idle = 0; rd(8'h14, "R6"); rd(8'h14, "R6"); tx_idle = 1;
        line_err = 4'b1000; rd(8'h14, "R6"); line_err = 0; rd(8'h14, "R6"); rd(8'h14, "R6");
        // R11: external receive
        rx_avail = 1; rx_byte = 8'h5A; rd(8'h14, "R11"); rd(8'h00, "R11");
        rx_avail = 0; rd(8'h00, "R11"); rd(8'h14, "R11");
        // R7/R8: loopback
        wr(8'h10, 16'h0010, "R7");
        rx_avail = 1; rx_byte = 8'hC4;
        wr(8'h00, 16'h0077, "R7"); rd(8'h14, "R11"); rd(8'h00, "R7");
        rd(8'h00, "R8"); rd(8'h14, "R8");
        wr(8'h00, 16'h0021, "R7"); wr(8'h00, 16'h0022, "R7"); rd(8'h00, "R7"); rd(8'h00, "R7");
        wr(8'h10, 16'h0000, "R8"); rd(8'h00, "R11"); rx_avail = 0;
        // R9: tx interrupt
        wr(8'h04, 16'h0002, "R9"); wr(8'h00, 16'h0041, "R9"); idle(2, "R9");
        wr(8'h00, 16'h0042, "R9"); wr(8'h00, 16'h0043, "R9"); idle(1, "R9");
        wr(8'h04, 16'h0000, "R9"); wr(8'h00, 16'h0044, "R9"); idle(1, "R9");
        // R10: polling, with reads at every phase of the poll window
        wr(8'h04, 16'h0001, "R10");
        idle(2 * P + 3, "R10");
        for (int g = 0; g < P + 2; g++) begin
            rx_avail = 1; rx_byte = 8'(g);
            idle(g, "R10");
            rd(8'h00, "R10");
            rx_avail = 0;
        end
        wr(8'h10, 16'h0010, "R10");
        for (int g = 0; g < P + 2; g++) begin
            wr(8'h00, 16'(8'h80 + g), "R10");
            idle(g, "R10");
            rd(8'h00, "R10");
        end
        wr(8'h10, 16'h0000, "R10");
        rx_avail = 1; idle(P + 3, "R10");
        wr(8'h04, 16'h0000, "R10"); idle(2 * P, "R10");
        wr(8'h04, 16'h0001, "R10"); idle(P + 2, "R10");
        rx_avail = 0; idle(2, "R10");
        finish_run();
    end
endmodule